// File: doc/BRIEF.md
# Guest Activity and Interruptibility Consistency Checker

This block decides whether a proposed guest state is self-consistent before a virtual machine is entered. It looks at the requested activity state, the 32-bit interruptibility word, the privilege level of the stack segment, the interrupt-enable flag, and a pending event to inject (valid, type, vector). It also looks at three control and status bits: request to enter system-management mode, virtual-NMI handling, and whether the processor is already in system-management mode. It reports either a pass or the number of the rule that the state breaks.

A caller places all the fields on the inputs and pulses `start` for one cycle. On the next cycle `done` pulses for one cycle. `pass` and `rule_code` then hold the result until the next `start`. When several rules fail together, the lowest rule number is reported.

Activity encodings: 0 = active, 1 = halted, 2 = shutdown, 3 = wait-for-startup-IPI. Injection type encodings: 0 = external interrupt, 2 = NMI, 3 = hardware exception. Interruptibility bit positions: bit 0 = blocking after STI, bit 1 = blocking after MOV SS, bit 2 = SMI blocking, bit 3 = NMI blocking, bits 31:4 reserved.

Top module: `act_intr_chk`

## Requirements
- R1: A one-cycle `start` gives exactly one `done` pulse in the following cycle. `done` is low at all other times. `pass` and `rule_code` change only in the cycle after a `start`.
- R2: `pass` is 1 exactly when `rule_code` is 0. After reset, `done`, `pass` and `rule_code` are all 0.
- R3: Code 1 is reported when the activity value is greater than 3.
- R4: Code 2 is reported when the activity is halted (1) and the stack-segment privilege level is not 0.
- R5: Code 3 is reported when the activity is not active (0) and interruptibility bit 0 or bit 1 is set.
- R6: Code 4 is reported when a valid injection is not allowed by the activity state. Active allows every event. Halted allows type 0, type 2, and type 3 with vector 1 or vector 18. Shutdown allows type 2, and type 3 with vector 18. Wait-for-startup-IPI allows no event.
- R7: Code 5 is reported when the activity is wait-for-startup-IPI (3) and the enter-SMM control is 1.
- R8: Code 6 is reported when any interruptibility bit in 31:4 is set.
- R9: Code 7 is reported when interruptibility bits 0 and 1 are both set.
- R10: Code 8 is reported when interruptibility bit 0 is set while the interrupt-enable flag is 0.
- R11: Code 9 is reported when bit 0 or bit 1 is set and a valid type-0 event is injected. Code 10 is reported when bit 1 is set and a valid type-2 event is injected.
- R12: Code 11 is reported when interruptibility bit 2 is set while not in SMM. Code 12 is reported when bit 2 is clear while the enter-SMM control is 1.
- R13: Code 13 is reported when interruptibility bit 3 is set, the virtual-NMI control is 1, and a valid type-2 event is injected.
- R14: When several rules fail, the smallest failing code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to evaluate the inputs |
| act_state | input | ACT_W (32) | Requested activity state |
| intr_state | input | INTR_W (32) | Interruptibility word |
| ss_dpl | input | 2 | Stack-segment privilege level |
| if_flag | input | 1 | Interrupt-enable flag |
| inj_valid | input | 1 | An event is to be injected |
| inj_type | input | 3 | Type of the injected event |
| inj_vector | input | 8 | Vector of the injected event |
| smm_entry_ctl | input | 1 | Entry into system-management mode is requested |
| vnmi_ctl | input | 1 | Virtual-NMI handling is enabled |
| in_smm | input | 1 | The processor is currently in system-management mode |
| done | output | 1 | Result-valid pulse |
| pass | output | 1 | The fields are consistent |
| rule_code | output | 4 | Lowest failing rule number, or 0 |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that every field input is steady in the cycle `start` is high, because the rule-code checks look at the values captured on that edge. The bench drives all fields and `start` on the falling clock edge. It raises `start` for exactly one cycle and leaves at least one idle cycle between requests. Each scenario begins from a clean baseline: active state, interrupt-enable flag set, no injection, and an all-zero interruptibility word. It then changes only the fields its rule needs, so the expected code is the one rule under test.

// File: rtl/act_chk_pkg.sv
package act_chk_pkg;
  localparam int N_RULES = 13;
  localparam int CODE_W  = 4;

  typedef enum logic [1:0] {
    ACT_RUN  = 2'd0,
    ACT_HALT = 2'd1,
    ACT_DOWN = 2'd2,
    ACT_SIPI = 2'd3
  } act_e;

  localparam logic [2:0] EV_EXTINT = 3'd0;
  localparam logic [2:0] EV_NMI    = 3'd2;
  localparam logic [2:0] EV_HWEXC  = 3'd3;

  localparam logic [7:0] VEC_DEBUG = 8'd1;
  localparam logic [7:0] VEC_MCHK  = 8'd18;
endpackage

// File: rtl/act_inj_filter.sv
module act_inj_filter
  import act_chk_pkg::*;
(
  input  logic [1:0] act_low,
  input  logic [2:0] inj_type,
  input  logic [7:0] inj_vector,
  output logic       allowed
);
  logic is_mchk, is_dbg;

  always_comb begin
    is_mchk = (inj_type == EV_HWEXC) && (inj_vector == VEC_MCHK);
    is_dbg  = (inj_type == EV_HWEXC) && (inj_vector == VEC_DEBUG);
    unique case (act_e'(act_low))
      ACT_RUN:  allowed = 1'b1;
      ACT_HALT: allowed = (inj_type == EV_EXTINT) || (inj_type == EV_NMI) || is_dbg || is_mchk;
      ACT_DOWN: allowed = (inj_type == EV_NMI) || is_mchk;
      default:  allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/act_rule_eval.sv
module act_rule_eval
  import act_chk_pkg::*;
#(
  parameter int ACT_W  = 32,
  parameter int INTR_W = 32
) (
  input  logic [ACT_W-1:0]  act_state,
  input  logic [INTR_W-1:0] intr_state,
  input  logic [1:0]        ss_dpl,
  input  logic              if_flag,
  input  logic              inj_valid,
  input  logic [2:0]        inj_type,
  input  logic [7:0]        inj_vector,
  input  logic              smm_entry_ctl,
  input  logic              vnmi_ctl,
  input  logic              in_smm,
  output logic [N_RULES-1:0] fail_vec
);
  localparam int RSV_LO = 4;

  logic act_oor, is_run, is_halt, is_sipi, inj_ok;
  logic b_sti, b_movss, b_smi, b_nmi, rsv_set;
  logic inj_ext, inj_nmi;

  act_inj_filter u_filt (
    .act_low   (act_state[1:0]),
    .inj_type  (inj_type),
    .inj_vector(inj_vector),
    .allowed   (inj_ok)
  );

  always_comb begin
    act_oor = (act_state > ACT_W'(3));
    is_run  = !act_oor && (act_state[1:0] == ACT_RUN);
    is_halt = !act_oor && (act_state[1:0] == ACT_HALT);
    is_sipi = !act_oor && (act_state[1:0] == ACT_SIPI);
    b_sti   = intr_state[0];
    b_movss = intr_state[1];
    b_smi   = intr_state[2];
    b_nmi   = intr_state[3];
    rsv_set = |intr_state[INTR_W-1:RSV_LO];
    inj_ext = inj_valid && (inj_type == EV_EXTINT);
    inj_nmi = inj_valid && (inj_type == EV_NMI);

    fail_vec[0]  = act_oor;
    fail_vec[1]  = is_halt && (ss_dpl != 2'd0);
    fail_vec[2]  = !is_run && (b_sti || b_movss);
    fail_vec[3]  = !act_oor && inj_valid && !inj_ok;
    fail_vec[4]  = is_sipi && smm_entry_ctl;
    fail_vec[5]  = rsv_set;
    fail_vec[6]  = b_sti && b_movss;
    fail_vec[7]  = b_sti && !if_flag;
    fail_vec[8]  = inj_ext && (b_sti || b_movss);
    fail_vec[9]  = inj_nmi && b_movss;
    fail_vec[10] = b_smi && !in_smm;
    fail_vec[11] = !b_smi && smm_entry_ctl;
    fail_vec[12] = b_nmi && vnmi_ctl && inj_nmi;
  end
endmodule

// File: rtl/act_prio_pick.sv
module act_prio_pick #(
  parameter int N = 13,
  parameter int W = 4
) (
  input  logic [N-1:0] fails,
  output logic [W-1:0] code
);
  logic [N:0]   below;
  logic [N-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign below[i+1] = below[i] | fails[i];
    assign first[i]   = fails[i] & ~below[i];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      code = code | (first[i] ? W'(i + 1) : W'(0));
    end
  end
endmodule

// File: rtl/act_intr_chk.sv
module act_intr_chk
  import act_chk_pkg::*;
#(
  parameter int ACT_W  = 32,
  parameter int INTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ACT_W-1:0]  act_state,
  input  logic [INTR_W-1:0] intr_state,
  input  logic [1:0]        ss_dpl,
  input  logic              if_flag,
  input  logic              inj_valid,
  input  logic [2:0]        inj_type,
  input  logic [7:0]        inj_vector,
  input  logic              smm_entry_ctl,
  input  logic              vnmi_ctl,
  input  logic              in_smm,
  output logic              done,
  output logic              pass,
  output logic [3:0]        rule_code
);
  logic [N_RULES-1:0] fail_vec;
  logic [CODE_W-1:0]  code_c;
  logic               done_d, pass_d, res_en;
  logic [CODE_W-1:0]  code_d;
  logic               done_q, pass_q;
  logic [CODE_W-1:0]  code_q;

  act_rule_eval #(.ACT_W(ACT_W), .INTR_W(INTR_W)) u_eval (
    .act_state    (act_state),
    .intr_state   (intr_state),
    .ss_dpl       (ss_dpl),
    .if_flag      (if_flag),
    .inj_valid    (inj_valid),
    .inj_type     (inj_type),
    .inj_vector   (inj_vector),
    .smm_entry_ctl(smm_entry_ctl),
    .vnmi_ctl     (vnmi_ctl),
    .in_smm       (in_smm),
    .fail_vec     (fail_vec)
  );

  act_prio_pick #(.N(N_RULES), .W(CODE_W)) u_pick (
    .fails(fail_vec),
    .code (code_c)
  );

  always_comb begin
    res_en = start;
    done_d = start;
    pass_d = (fail_vec == '0);
    code_d = code_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= done_d;
      if (res_en) begin
        pass_q <= pass_d;
        code_q <= code_d;
      end
    end
  end

  assign done      = done_q;
  assign pass      = pass_q;
  assign rule_code = code_q;

  a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r1_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(rule_code) && $stable(pass)));
  a_r2_pass_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (rule_code == '0)));
  a_r3_range_first: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(act_state > ACT_W'(3))) |-> (rule_code == 4'd1));
  a_r9_both_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(act_state == '0) && $past(intr_state == INTR_W'(3))) |-> (rule_code == 4'd7));
  a_r14_fail_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(intr_state[INTR_W-1:4] != '0)) |-> (rule_code != 4'd0 && rule_code <= 4'd6));
endmodule

// File: tb/act_intr_chk_tb_top.sv
module act_intr_chk_tb_top;
  localparam int CLK_HALF = 5;

  logic        clk, rst_n, start;
  logic [31:0] act_state, intr_state;
  logic [1:0]  ss_dpl;
  logic        if_flag, inj_valid, smm_entry_ctl, vnmi_ctl, in_smm;
  logic [2:0]  inj_type;
  logic [7:0]  inj_vector;
  logic        done, pass;
  logic [3:0]  rule_code;

  int total = 0;
  int bad   = 0;

  act_intr_chk dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .act_state(act_state), .intr_state(intr_state), .ss_dpl(ss_dpl),
    .if_flag(if_flag), .inj_valid(inj_valid), .inj_type(inj_type),
    .inj_vector(inj_vector), .smm_entry_ctl(smm_entry_ctl),
    .vnmi_ctl(vnmi_ctl), .in_smm(in_smm),
    .done(done), .pass(pass), .rule_code(rule_code)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic base();
    act_state = 0; intr_state = 0; ss_dpl = 0; if_flag = 1;
    inj_valid = 0; inj_type = 0; inj_vector = 0;
    smm_entry_ctl = 0; vnmi_ctl = 0; in_smm = 0;
  endtask

  task automatic run(string req, int exp_code);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, int'(done), 1);
    chk({req, " code"}, int'(rule_code), exp_code);
    chk({req, " pass"}, int'(pass), (exp_code == 0) ? 1 : 0);
    @(negedge clk);
    chk({"R1 done low"}, int'(done), 0);
    chk({"R1 code held"}, int'(rule_code), exp_code);
    base();
  endtask

  task automatic t_reset();
    chk("R2 reset done", int'(done), 0);
    chk("R2 reset pass", int'(pass), 0);
    chk("R2 reset code", int'(rule_code), 0);
  endtask

  task automatic t_clean();
    base(); run("R2 clean", 0);
  endtask

  task automatic t_r3();
    act_state = 4; run("R3 act 4", 1);
    act_state = 32'h8000_0000; run("R3 act large", 1);
  endtask

  task automatic t_r4();
    act_state = 1; ss_dpl = 2; run("R4 halt dpl2", 2);
    act_state = 1; ss_dpl = 0; run("R4 halt dpl0", 0);
  endtask

  task automatic t_r5();
    act_state = 1; intr_state = 1; run("R5 halt sti", 3);
    act_state = 2; intr_state = 2; run("R5 down movss", 3);
    act_state = 0; intr_state = 2; run("R5 run movss", 0);
  endtask

  task automatic t_r6();
    act_state = 1; inj_valid = 1; inj_type = 0; run("R6 halt ext", 0);
    act_state = 1; inj_valid = 1; inj_type = 3; inj_vector = 14; run("R6 halt exc14", 4);
    act_state = 1; inj_valid = 1; inj_type = 3; inj_vector = 1; run("R6 halt exc1", 0);
    act_state = 2; inj_valid = 1; inj_type = 0; run("R6 down ext", 4);
    act_state = 2; inj_valid = 1; inj_type = 3; inj_vector = 18; run("R6 down mchk", 0);
    act_state = 2; inj_valid = 1; inj_type = 3; inj_vector = 1; run("R6 down exc1", 4);
    act_state = 3; inj_valid = 1; inj_type = 2; run("R6 sipi nmi", 4);
    act_state = 0; inj_valid = 1; inj_type = 6; inj_vector = 3; run("R6 run any", 0);
    act_state = 3; inj_valid = 0; inj_type = 2; run("R6 sipi invalid", 0);
  endtask

  task automatic t_r7();
    act_state = 3; smm_entry_ctl = 1; intr_state = 4; in_smm = 1; run("R7 sipi smm", 5);
    act_state = 0; smm_entry_ctl = 1; intr_state = 4; in_smm = 1; run("R7 run smm", 0);
  endtask

  task automatic t_r8();
    intr_state = 32'h10; run("R8 bit4", 6);
    intr_state = 32'h8000_0000; run("R8 bit31", 6);
  endtask

  task automatic t_r9();
    intr_state = 3; run("R9 both", 7);
  endtask

  task automatic t_r10();
    intr_state = 1; if_flag = 0; run("R10 sti if0", 8);
    intr_state = 1; if_flag = 1; run("R10 sti if1", 0);
  endtask

  task automatic t_r11();
    intr_state = 2; inj_valid = 1; inj_type = 0; run("R11 movss ext", 9);
    intr_state = 1; inj_valid = 1; inj_type = 0; run("R11 sti ext", 9);
    intr_state = 2; inj_valid = 1; inj_type = 2; run("R11 movss nmi", 10);
    intr_state = 1; inj_valid = 1; inj_type = 2; run("R11 sti nmi", 0);
  endtask

  task automatic t_r12();
    intr_state = 4; in_smm = 0; run("R12 smi out", 11);
    intr_state = 0; in_smm = 1; smm_entry_ctl = 1; run("R12 smm no smi", 12);
  endtask

  task automatic t_r13();
    intr_state = 8; vnmi_ctl = 1; inj_valid = 1; inj_type = 2; run("R13 vnmi nmi", 13);
    intr_state = 8; vnmi_ctl = 0; inj_valid = 1; inj_type = 2; run("R13 no vnmi", 0);
  endtask

  task automatic t_r14();
    act_state = 5; intr_state = 32'h13; if_flag = 0; run("R14 range first", 1);
    act_state = 1; ss_dpl = 1; intr_state = 3; run("R14 dpl first", 2);
    intr_state = 32'h17; run("R14 rsv first", 6);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; base();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean(); t_r3(); t_r4(); t_r5(); t_r6(); t_r7(); t_r8();
    t_r9(); t_r10(); t_r11(); t_r12(); t_r13(); t_r14();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule